// File: doc/BRIEF.md
# Bit-Serial Block Cipher Front End and Sequencer

This block wraps a 128-bit block cipher core with bit-serial access. A key shifter gathers the key one qualified bit at a time. A data shifter gathers the block the same way. An output shifter hands the core's result back one bit per clock. A Moore state machine decides which shifter is live, when the core is launched, and when the result is sent out. The core itself is reached through a start pulse and a done strobe, and its arithmetic lies outside this block.

There are two operating modes. In discrete mode every step (data load, launch, unload) waits for its own operator command, which suits bring-up and step-by-step testing. In continuous mode the operator only asks for the key. Loading, launching and unloading then follow one another without further commands. After each result the machine goes back to waiting for the next data block and keeps the loaded key.

Top module: `ser_cipher_ctrl`

## Requirements
- R1: After reset, all four status flags (`key_req`, `in_req`, `busy`, `out_rdy`), `out_vld` and `core_start` are low, and `core_key` and `core_din` are zero.
- R2: From idle, a `cmd_key` pulse raises `key_req` on the next cycle. The other commands have no effect in idle, and `key_req` only rises after a `cmd_key`.
- R3: While `key_req` is high, each clock with `key_vld` high shifts `key_bit` into `core_key`, most significant bit first, so the first accepted bit ends in bit W-1. Key bits with `key_vld` low, or given outside the key step, leave `core_key` unchanged.
- R4: On the clock that accepts the W-th key bit, the machine moves on: `key_req` falls and `in_req` rises.
- R5: In discrete mode, data bits given while `in_req` is high but before `cmd_data` leave `core_din` unchanged. After `cmd_data`, W bits qualified by `dat_vld` fill `core_din` MSB first. After the last of them, `in_req` falls and `busy` rises. `core_din` changes only while `in_req` is high.
- R6: In discrete mode, no `core_start` is issued until `cmd_run`. After it, exactly one single-cycle `core_start` pulse is issued, and only while `busy` is high.
- R7: A `core_done` strobe that arrives after the launch captures `core_dout` and raises `out_rdy` on the next cycle.
- R8: In discrete mode, `out_vld` stays low while `out_rdy` is high until `cmd_out`. It then stays high for W consecutive cycles, with `out_bit` giving the result MSB first. The machine then returns to idle. `out_vld` is only ever high together with `out_rdy`.
- R9: In continuous mode, after one `cmd_key`, the steps that follow need no commands: the data shift, the core launch and the result shift each start on their own. After the result has been sent, `in_req` is high again, the key is still held, and a further block can be processed with it.
- R10: At most one of the four status flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cont_mode | input | 1 | 1 = continuous mode, 0 = discrete mode |
| cmd_key | input | 1 | Operator command: start key acquisition (from idle) |
| cmd_data | input | 1 | Operator command: start data shift (discrete mode) |
| cmd_run | input | 1 | Operator command: launch the core (discrete mode) |
| cmd_out | input | 1 | Operator command: start result shift (discrete mode) |
| key_bit | input | 1 | Serial key bit |
| key_vld | input | 1 | Qualifies `key_bit` |
| dat_bit | input | 1 | Serial data bit |
| dat_vld | input | 1 | Qualifies `dat_bit` |
| key_req | output | 1 | Key step is active |
| in_req | output | 1 | Data step is active |
| busy | output | 1 | Core step is active |
| out_rdy | output | 1 | Result step is active |
| out_bit | output | 1 | Serial result bit |
| out_vld | output | 1 | Qualifies `out_bit` |
| core_start | output | 1 | One-cycle launch pulse to the core |
| core_key | output | W | Gathered key |
| core_din | output | W | Gathered data block |
| core_done | input | 1 | Core completion strobe |
| core_dout | input | W | Core result, sampled on `core_done` |

## Verification
Key and data words are swept through all-zero, all-one and alternating patterns, walking single bits and hashed values. A stub core returns a rotate-and-XOR of the two words, so a swapped bit order, a key and data mix-up or a lost bit each shows up as a wrong serial result. Gaps with inverted, unqualified bits are placed inside every serial load, and stray bits and commands are given in the wrong steps. These show whether qualification and step gating hold. The same patterns are then run in continuous mode across two blocks. This separates automatic sequencing and key retention from the command-driven path.

// File: rtl/ser_cipher_ctrl.sv
module ser_cipher_ctrl #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cont_mode,
  input  logic         cmd_key,
  input  logic         cmd_data,
  input  logic         cmd_run,
  input  logic         cmd_out,
  input  logic         key_bit,
  input  logic         key_vld,
  input  logic         dat_bit,
  input  logic         dat_vld,
  output logic         key_req,
  output logic         in_req,
  output logic         busy,
  output logic         out_rdy,
  output logic         out_bit,
  output logic         out_vld,
  output logic         core_start,
  output logic [W-1:0] core_key,
  output logic [W-1:0] core_din,
  input  logic         core_done,
  input  logic [W-1:0] core_dout
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [2:0] {S_IDLE, S_KEY, S_DIN, S_CRYPT, S_DOUT} st_t;

  st_t           st;
  logic          run;
  logic [CW-1:0] cnt;
  logic [W-1:0]  ksr, dsr, osr;

  wire key_shift  = (st == S_KEY) && run && key_vld;
  wire din_shift  = (st == S_DIN) && run && dat_vld;
  wire dout_shift = (st == S_DOUT) && run;
  wire crypt_done = (st == S_CRYPT) && run && (cnt != '0) && core_done;
  wire arm = !run && (((st == S_DIN) && cmd_data) ||
                      ((st == S_CRYPT) && cmd_run) ||
                      ((st == S_DOUT) && cmd_out));

  assign key_req    = (st == S_KEY);
  assign in_req     = (st == S_DIN);
  assign busy       = (st == S_CRYPT);
  assign out_rdy    = (st == S_DOUT);
  assign out_vld    = dout_shift;
  assign out_bit    = osr[W-1];
  assign core_start = (st == S_CRYPT) && run && (cnt == '0);
  assign core_key   = ksr;
  assign core_din   = dsr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      run <= 1'b0;
      cnt <= '0;
      ksr <= '0;
      dsr <= '0;
      osr <= '0;
    end else begin
      if (arm) run <= 1'b1;
      case (st)
        S_IDLE: if (cmd_key) begin
          st  <= S_KEY;
          run <= 1'b1;
          cnt <= '0;
        end
        S_KEY: if (key_shift) begin
          ksr <= {ksr[W-2:0], key_bit};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            st  <= S_DIN;
            run <= cont_mode;
            cnt <= '0;
          end
        end
        S_DIN: if (din_shift) begin
          dsr <= {dsr[W-2:0], dat_bit};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            st  <= S_CRYPT;
            run <= cont_mode;
            cnt <= '0;
          end
        end
        S_CRYPT: begin
          if (core_start) cnt <= CW'(1);
          if (crypt_done) begin
            osr <= core_dout;
            st  <= S_DOUT;
            run <= cont_mode;
            cnt <= '0;
          end
        end
        S_DOUT: if (dout_shift) begin
          osr <= {osr[W-2:0], 1'b0};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            st  <= cont_mode ? S_DIN : S_IDLE;
            run <= cont_mode;
            cnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ser_cipher_ctrl_chk.sv
module ser_cipher_ctrl_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_key,
  input logic         key_req,
  input logic         in_req,
  input logic         busy,
  input logic         out_rdy,
  input logic         out_vld,
  input logic         core_start,
  input logic [W-1:0] core_key,
  input logic [W-1:0] core_din
);
  p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_req, in_req, busy, out_rdy}));

  p_key_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_req) |-> $past(cmd_key));

  p_key_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !key_req |=> $stable(core_key));

  p_din_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_req |=> $stable(core_din));

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  p_start_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> busy);

  p_out_in_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_rdy);
endmodule

bind ser_cipher_ctrl ser_cipher_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/tb_ser_cipher_ctrl.sv
module tb_ser_cipher_ctrl;
  localparam int W = 128;

  logic clk = 0;
  logic rst_n = 0;
  logic cont_mode = 0, cmd_key = 0, cmd_data = 0, cmd_run = 0, cmd_out = 0;
  logic key_bit = 0, key_vld = 0, dat_bit = 0, dat_vld = 0;
  logic key_req, in_req, busy, out_rdy, out_bit, out_vld, core_start;
  logic [W-1:0] core_key, core_din;
  logic core_done = 0;
  logic [W-1:0] core_dout = '0;

  int n_chk = 0, n_bad = 0, nstart = 0, lat = 0, cyc = 0;

  always #10 clk = ~clk;

  ser_cipher_ctrl #(.W(W)) dut (.*);

  function automatic logic [W-1:0] model(input logic [W-1:0] k, input logic [W-1:0] d);
    return {d[63:0], d[127:64]} ^ k;
  endfunction

  function automatic logic [W-1:0] gen(input int i);
    if (i == 0) return '0;
    if (i == 1) return '1;
    if (i == 2) return {32{4'hA}};
    return {4{32'h9E3779B9 * (i + 1)}} ^ (128'h1 << ((i * 37) % 128));
  endfunction

  always @(posedge clk) begin
    core_done <= 1'b0;
    if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        core_done <= 1'b1;
        core_dout <= model(core_key, core_din);
      end
    end else if (core_start) begin
      lat <= 3;
      nstart <= nstart + 1;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic pulse(ref logic c);
    c = 1;
    @(negedge clk);
    c = 0;
  endtask

  task automatic send(input logic [W-1:0] v, input bit is_key);
    for (int i = W - 1; i >= 0; i--) begin
      if (i % 3 == 2) begin
        if (is_key) begin key_vld = 0; key_bit = ~v[i]; end
        else begin dat_vld = 0; dat_bit = ~v[i]; end
        @(negedge clk);
      end
      if (is_key) begin key_vld = 1; key_bit = v[i]; end
      else begin dat_vld = 1; dat_bit = v[i]; end
      @(negedge clk);
    end
    key_vld = 0;
    dat_vld = 0;
  endtask

  task automatic stray(input bit is_key);
    for (int i = 0; i < 20; i++) begin
      if (is_key) begin key_vld = 1; key_bit = i[0]; end
      else begin dat_vld = 1; dat_bit = ~i[0]; end
      @(negedge clk);
    end
    key_vld = 0;
    dat_vld = 0;
  endtask

  task automatic collect(output logic [W-1:0] v, output bit ok);
    int t = 0;
    v = '0;
    while (!out_vld && t < 400) begin @(negedge clk); t++; end
    ok = out_vld;
    for (int i = 0; i < W; i++) begin
      if (!out_vld) ok = 0;
      v = {v[W-2:0], out_bit};
      @(negedge clk);
    end
  endtask

  initial begin
    logic [W-1:0] k, d, r, prev_d;
    bit ok;
    int s0;
    prev_d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 flags", {key_req, in_req, busy, out_rdy, out_vld, core_start}, 0);
    check("R1 key", core_key, '0);
    check("R1 din", core_din, '0);

    pulse(cmd_data); pulse(cmd_run); pulse(cmd_out);
    stray(1); stray(0);
    check("R2 idle ignores cmds", {key_req, in_req, busy, out_rdy, out_vld}, 0);
    check("R3 idle key bits ignored", core_key, '0);

    for (int p = 0; p < 8; p++) begin
      k = gen(p);
      d = gen(p + 3);
      pulse(cmd_key);
      check("R2 key_req", {key_req, in_req}, 2'b10);
      send(k, 1);
      check("R3 key gathered", core_key, k);
      check("R4 in_req", {key_req, in_req}, 2'b01);
      stray(0);
      check("R5 data before cmd ignored", core_din, prev_d);
      stray(1);
      check("R3 key bits outside key step", core_key, k);
      pulse(cmd_data);
      send(d, 0);
      prev_d = d;
      check("R5 data gathered", core_din, d);
      check("R5 busy", {in_req, busy}, 2'b01);
      s0 = nstart;
      repeat (8) @(negedge clk);
      check("R6 no start before cmd", 32'(nstart), 32'(s0));
      pulse(cmd_run);
      repeat (12) @(negedge clk);
      check("R6 one start", 32'(nstart), 32'(s0 + 1));
      check("R7 out_rdy", {busy, out_rdy}, 2'b01);
      check("R8 no out before cmd", {31'd0, out_vld}, 0);
      pulse(cmd_out);
      collect(r, ok);
      check("R8 out_vld run", {31'd0, ok}, 1);
      check("R8 result", r, model(k, d));
      check("R8 back to idle", {key_req, in_req, busy, out_rdy, out_vld}, 0);
    end

    cont_mode = 1;
    k = gen(11);
    pulse(cmd_key);
    send(k, 1);
    for (int b = 0; b < 3; b++) begin
      d = gen(20 + b);
      check("R9 in_req again", {in_req, 31'd0}, {1'b1, 31'd0});
      check("R9 key kept", core_key, k);
      send(d, 0);
      collect(r, ok);
      check("R9 auto output", {31'd0, ok}, 1);
      check("R9 result", r, model(k, d));
    end
    summary();
  end
endmodule